// File: doc/BRIEF.md
# Configurable Product-Term Logic Cell

This block is one logic cell of a small programmable-logic fabric. It takes 18 signals from a routing bus and forms product terms in a programmable AND plane. For each input, each term can require the true value, require the complement, or ignore the input. Twenty of these terms feed four output slices. Each slice is set to one of two paths. The fast path ORs its own group of four terms. The wide path ORs any chosen subset of the twenty terms and can XOR the result with the first term of the slice's group.

Each slice can drive its output straight from the logic or through a register. Three further terms control the registers and the cell's edge. The first can reset all four registers asynchronously. The second can replace the global clock as the register clock. The third is brought out as an output enable for the attached I/O cells. All configuration is presented as static parallel inputs.

Top module: `pt_logic_cell`

## Requirements
- R1: Term t is configured by `and_cfg[t*36 + 2*i +: 2]` for each input i. Code 00 ignores the input. Code 01 requires `din[i]`=1. Code 10 requires `din[i]`=0. Code 11 makes the term constant 0. A term with every code 00 is constant 1. Terms 0..19 are logic terms, term 20 is the reset term, term 21 is the clock term and term 22 is the enable term.
- R2: When `byp_cfg[k]`=1, slice k is the OR of terms 4k..4k+3. In that case `sum_cfg` and `xor_cfg[k]` have no effect on the slice.
- R3: When `byp_cfg[k]`=0 and `xor_cfg[k]`=0, slice k is the OR of every term t for which `sum_cfg[k*20 + t]`=1. With no such term selected, the slice is 0.
- R4: When `byp_cfg[k]`=0 and `xor_cfg[k]`=1, slice k is the R3 sum XORed with term 4k.
- R5: When `reg_cfg[k]`=0, `dout[k]` follows slice k combinationally, with no clock edge needed.
- R6: When `reg_cfg[k]`=1 and `ptclk_sel`=0, `dout[k]` takes the value of slice k at each rising edge of `clk` and holds it between edges.
- R7: When `ptclk_sel`=1, the registers capture on the rising edge of the clock term. Edges of `clk` have no effect on them.
- R8: When `ptrst_en`=1 and the reset term is 1, all registers go to 0 at once, with no clock edge. When `ptrst_en`=0, the reset term has no effect.
- R9: While `rst_n` is low, all registers are 0 asynchronously. Registered outputs therefore read 0.
- R10: `oe` equals the enable term at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Global register clock |
| rst_n | input | 1 | Active-low asynchronous clear of all registers |
| din | input | 18 | Logic inputs from the routing bus |
| and_cfg | input | 828 | AND-plane codes, 2 bits per input per term, 23 terms |
| sum_cfg | input | 80 | Wide-path term select, 20 bits per slice |
| xor_cfg | input | 4 | XOR with the slice's first group term, per slice |
| byp_cfg | input | 4 | Selects the four-term fast path, per slice |
| reg_cfg | input | 4 | Registered (1) or combinational (0) output, per slice |
| ptclk_sel | input | 1 | Registers clocked by the clock term instead of `clk` |
| ptrst_en | input | 1 | Lets the reset term clear the registers |
| dout | output | 4 | Slice outputs |
| oe | output | 1 | Output enable from the enable term |

## Verification
A wrong AND-plane code shows at once on a combinational output as a slice that is stuck or that follows the wrong input. The bench sweeps every value of the inputs that the terms use, so such an error appears within one sweep. A slice wired to the wrong path or to the wrong XOR term gives a wrong value for some input pattern of the same sweep. A fault in the register clocking or reset appears one edge later as a held value that does not match. It also appears as a nonzero output while a reset condition is active, and the bench checks that before the next clock edge.

// File: rtl/pt_logic_pkg.sv
`timescale 1ns/1ps
package pt_logic_pkg;

   // Per-input literal code inside a product-term row
   typedef enum logic [1:0] {
      LIT_ANY   = 2'b00,
      LIT_HIGH  = 2'b01,
      LIT_LOW   = 2'b10,
      LIT_NEVER = 2'b11
   } lit_sel_e;

   // Control terms placed after the logic terms
   localparam int CTL_RST   = 0;
   localparam int CTL_CLK   = 1;
   localparam int CTL_OE    = 2;
   localparam int CTL_TERMS = 3;

   function automatic logic lit_pass(input logic [1:0] sel, input logic x);
      return (~sel[0] | x) & (~sel[1] | ~x);
   endfunction

endpackage

// File: rtl/pt_and_plane.sv
`timescale 1ns/1ps
module pt_and_plane
   import pt_logic_pkg::*;
#(
   parameter int N_IN    = 18,
   parameter int N_TERMS = 23
) (
   input  logic [N_IN-1:0]           din,
   input  logic [N_TERMS*2*N_IN-1:0] mask,
   output logic [N_TERMS-1:0]        terms
);
   localparam int LIT_W = 2 * N_IN;

   if (N_IN < 1 || N_TERMS < 1) begin : g_bad_size
      $error("pt_and_plane: N_IN and N_TERMS must be positive");
   end

   for (genvar t = 0; t < N_TERMS; t++) begin : g_term
      logic [LIT_W-1:0] row;
      logic             hit;
      assign row = mask[t*LIT_W +: LIT_W];
      always_comb begin
         hit = 1'b1;
         for (int i = 0; i < N_IN; i++) begin
            hit = hit & lit_pass(row[2*i +: 2], din[i]);
         end
      end
      assign terms[t] = hit;
   end

endmodule

// File: rtl/pt_sum_unit.sv
`timescale 1ns/1ps
module pt_sum_unit #(
   parameter int N_PT = 20,
   parameter int GRP  = 4,
   parameter int SLOT = 0
) (
   input  logic [N_PT-1:0] terms,
   input  logic [N_PT-1:0] sel,
   input  logic            xor_en,
   input  logic            bypass,
   output logic            y
);
   localparam int BASE = SLOT * GRP;

   if (BASE + GRP > N_PT) begin : g_bad_slot
      $error("pt_sum_unit: fast group exceeds the term count");
   end

   logic fast;
   logic wide;
   logic flip;

   assign fast = |terms[BASE +: GRP];
   assign wide = |(terms & sel);
   assign flip = xor_en & terms[BASE];
   assign y    = bypass ? fast : (wide ^ flip);

endmodule

// File: rtl/pt_macrocell.sv
`timescale 1ns/1ps
module pt_macrocell #(
   parameter logic CLR_VAL = 1'b0
) (
   input  logic clk_g,
   input  logic clk_pt,
   input  logic use_pt_clk,
   input  logic arst,
   input  logic d,
   input  logic registered,
   output logic q,
   output logic y
);
   logic rclk;

   assign rclk = use_pt_clk ? clk_pt : clk_g;

   always_ff @(posedge rclk or posedge arst) begin
      if (arst) q <= CLR_VAL;
      else      q <= d;
   end

   assign y = registered ? q : d;

endmodule

// File: rtl/pt_logic_cell.sv
`timescale 1ns/1ps
module pt_logic_cell
   import pt_logic_pkg::*;
#(
   parameter int N_IN  = 18,
   parameter int N_OUT = 4,
   parameter int GRP   = 4,
   parameter int N_PT  = 20
) (
   input  logic                                   clk,
   input  logic                                   rst_n,
   input  logic [N_IN-1:0]                        din,
   input  logic [(N_PT+CTL_TERMS)*2*N_IN-1:0]     and_cfg,
   input  logic [N_OUT*N_PT-1:0]                  sum_cfg,
   input  logic [N_OUT-1:0]                       xor_cfg,
   input  logic [N_OUT-1:0]                       byp_cfg,
   input  logic [N_OUT-1:0]                       reg_cfg,
   input  logic                                   ptclk_sel,
   input  logic                                   ptrst_en,
   output logic [N_OUT-1:0]                       dout,
   output logic                                   oe
);
   localparam int N_ALL = N_PT + CTL_TERMS;

   if (N_OUT * GRP > N_PT) begin : g_bad_groups
      $error("pt_logic_cell: fast groups need more terms than N_PT");
   end
   if (GRP < 1 || N_OUT < 1) begin : g_bad_width
      $error("pt_logic_cell: GRP and N_OUT must be positive");
   end

   logic [N_ALL-1:0] terms_all;
   logic [N_PT-1:0]  logic_terms;
   logic             rst_term;
   logic             clk_term;
   logic             arst;
   logic [N_OUT-1:0] comb_bits;
   logic [N_OUT-1:0] q_bits;

   pt_and_plane #(
      .N_IN    (N_IN),
      .N_TERMS (N_ALL)
   ) u_plane (
      .din   (din),
      .mask  (and_cfg),
      .terms (terms_all)
   );

   assign logic_terms = terms_all[N_PT-1:0];
   assign rst_term    = terms_all[N_PT + CTL_RST];
   assign clk_term    = terms_all[N_PT + CTL_CLK];
   assign oe          = terms_all[N_PT + CTL_OE];
   assign arst        = ~rst_n | (ptrst_en & rst_term);

   for (genvar k = 0; k < N_OUT; k++) begin : g_slice
      pt_sum_unit #(
         .N_PT (N_PT),
         .GRP  (GRP),
         .SLOT (k)
      ) u_sum (
         .terms  (logic_terms),
         .sel    (sum_cfg[k*N_PT +: N_PT]),
         .xor_en (xor_cfg[k]),
         .bypass (byp_cfg[k]),
         .y      (comb_bits[k])
      );

      pt_macrocell #(
         .CLR_VAL (1'b0)
      ) u_cell (
         .clk_g      (clk),
         .clk_pt     (clk_term),
         .use_pt_clk (ptclk_sel),
         .arst       (arst),
         .d          (comb_bits[k]),
         .registered (reg_cfg[k]),
         .q          (q_bits[k]),
         .y          (dout[k])
      );
   end

endmodule

// File: rtl/pt_logic_cell_chk.sv
`timescale 1ns/1ps
module pt_logic_cell_chk #(
   parameter int N_OUT = 4,
   parameter int N_PT  = 20,
   parameter int GRP   = 4
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    ptclk_sel,
   input logic                    ptrst_en,
   input logic [N_OUT-1:0]        reg_cfg,
   input logic [N_OUT-1:0]        byp_cfg,
   input logic [N_OUT-1:0]        xor_cfg,
   input logic [N_OUT*N_PT-1:0]   sum_cfg,
   input logic [N_PT-1:0]         lterms,
   input logic                    rst_term,
   input logic                    clk_term,
   input logic [N_OUT-1:0]        comb,
   input logic [N_OUT-1:0]        q,
   input logic [N_OUT-1:0]        dout
);

   always @(posedge clk) begin
      if (rst_n === 1'b0) begin
         AST_GLOBAL_CLEAR: assert (q == '0) else $error("registers not clear in reset"); // R9
      end
   end

   AST_PTRST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (ptrst_en && rst_term) |-> (q == '0)) else $error("term reset failed"); // R8

   AST_PTCLK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (ptclk_sel && $past(ptclk_sel) && !ptrst_en && $past(!ptrst_en)
       && !clk_term && $past(!clk_term) && $past(rst_n)) |-> $stable(q))
      else $error("registers moved without a term clock edge"); // R7

   for (genvar k = 0; k < N_OUT; k++) begin : g_out
      AST_REG_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
         (!ptclk_sel && $past(!ptclk_sel) && !ptrst_en && $past(!ptrst_en)
          && reg_cfg[k] && $past(reg_cfg[k]) && $past(rst_n))
         |-> (dout[k] == $past(comb[k]))) else $error("registered output mismatch"); // R6

      AST_FAST_PATH: assert property (@(posedge clk) disable iff (!rst_n)
         byp_cfg[k] |-> (comb[k] == (|lterms[k*GRP +: GRP])))
         else $error("fast path mismatch"); // R2

      AST_WIDE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
         (!byp_cfg[k] && !xor_cfg[k] && ((lterms & sum_cfg[k*N_PT +: N_PT]) == '0))
         |-> !comb[k]) else $error("empty sum not zero"); // R3

      AST_XOR_PASS: assert property (@(posedge clk) disable iff (!rst_n)
         (!byp_cfg[k] && xor_cfg[k] && ((lterms & sum_cfg[k*N_PT +: N_PT]) == '0))
         |-> (comb[k] == lterms[k*GRP])) else $error("xor term mismatch"); // R4
   end

endmodule

bind pt_logic_cell pt_logic_cell_chk #(
   .N_OUT (N_OUT),
   .N_PT  (N_PT),
   .GRP   (GRP)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .ptclk_sel (ptclk_sel),
   .ptrst_en  (ptrst_en),
   .reg_cfg   (reg_cfg),
   .byp_cfg   (byp_cfg),
   .xor_cfg   (xor_cfg),
   .sum_cfg   (sum_cfg),
   .lterms    (logic_terms),
   .rst_term  (rst_term),
   .clk_term  (clk_term),
   .comb      (comb_bits),
   .q         (q_bits),
   .dout      (dout)
);

// File: tb/pt_logic_cell_test.sv
`timescale 1ns/1ps
module pt_logic_cell_test;
   import pt_logic_pkg::*;

   localparam int N_IN  = 18;
   localparam int N_OUT = 4;
   localparam int GRP   = 4;
   localparam int N_PT  = 20;
   localparam int N_ALL = N_PT + 3;
   localparam int LIT_W = 2 * N_IN;
   localparam int AND_W = N_ALL * LIT_W;
   localparam int SUM_W = N_OUT * N_PT;
   localparam int T_RST = 20;
   localparam int T_CLK = 21;
   localparam int T_OE  = 22;

   logic             clk = 1'b0;
   logic             rst_n = 1'b1;
   logic [N_IN-1:0]  din = '0;
   logic [AND_W-1:0] and_cfg = '0;
   logic [SUM_W-1:0] sum_cfg = '0;
   logic [N_OUT-1:0] xor_cfg = '0;
   logic [N_OUT-1:0] byp_cfg = '0;
   logic [N_OUT-1:0] reg_cfg = '0;
   logic             ptclk_sel = 1'b0;
   logic             ptrst_en = 1'b0;
   logic [N_OUT-1:0] dout;
   logic             oe;

   int errors = 0;
   int checks = 0;
   int cycles = 0;
   bit done = 0;
   logic [31:0] seed = 32'h1ACE5EED;

   always #5 clk = ~clk;

   pt_logic_cell uut (
      .clk(clk), .rst_n(rst_n), .din(din), .and_cfg(and_cfg), .sum_cfg(sum_cfg),
      .xor_cfg(xor_cfg), .byp_cfg(byp_cfg), .reg_cfg(reg_cfg),
      .ptclk_sel(ptclk_sel), .ptrst_en(ptrst_en), .dout(dout), .oe(oe)
   );

   function automatic logic [31:0] rnd();
      seed = seed ^ (seed << 13);
      seed = seed ^ (seed >> 17);
      seed = seed ^ (seed << 5);
      return seed;
   endfunction

   function automatic logic mterm(int t, logic [N_IN-1:0] x);
      logic r = 1'b1;
      for (int i = 0; i < N_IN; i++) begin
         logic [1:0] s = and_cfg[t*LIT_W + 2*i +: 2];
         if (s[0] && !x[i]) r = 1'b0;
         if (s[1] &&  x[i]) r = 1'b0;
      end
      return r;
   endfunction

   function automatic logic mout(int k, logic [N_IN-1:0] x);
      logic fast = 1'b0;
      logic wide = 1'b0;
      for (int g = 0; g < GRP; g++) fast = fast | mterm(k*GRP + g, x);
      if (byp_cfg[k]) return fast;
      for (int t = 0; t < N_PT; t++)
         if (sum_cfg[k*N_PT + t] && mterm(t, x)) wide = 1'b1;
      return wide ^ (xor_cfg[k] & mterm(k*GRP, x));
   endfunction

   function automatic logic [N_OUT-1:0] mvec(logic [N_IN-1:0] x);
      logic [N_OUT-1:0] v;
      for (int k = 0; k < N_OUT; k++) v[k] = mout(k, x);
      return v;
   endfunction

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic set_lit(int t, int i, logic [1:0] s);
      and_cfg[t*LIT_W + 2*i +: 2] = s;
   endtask

   task automatic clear_term(int t);
      and_cfg[t*LIT_W +: LIT_W] = '0;
   endtask

   task automatic ctl_terms();
      clear_term(T_RST); set_lit(T_RST, 16, LIT_HIGH);
      clear_term(T_CLK); set_lit(T_CLK, 17, LIT_HIGH);
      clear_term(T_OE);  set_lit(T_OE, 15, LIT_LOW); set_lit(T_OE, 14, LIT_HIGH);
   endtask

   // hand config: out0=1, out1=0, out2=din[3], out3=~din[3]
   task automatic hand_cfg();
      for (int t = 0; t < N_PT; t++) begin
         clear_term(t);
         set_lit(t, 0, LIT_NEVER);
      end
      clear_term(0);
      clear_term(8);  set_lit(8, 3, LIT_HIGH);
      clear_term(12); set_lit(12, 3, LIT_HIGH);
      sum_cfg = '0;
      sum_cfg[1*N_PT + 0] = 1'b1;
      sum_cfg[3*N_PT + 0] = 1'b1;
      byp_cfg = 4'b0011;
      xor_cfg = 4'b1110;
      ctl_terms();
   endtask

   task automatic rand_cfg(int span);
      for (int t = 0; t < N_PT; t++) begin
         int nlit;
         clear_term(t);
         nlit = (rnd() % 16 == 0) ? 0 : 1 + int'(rnd() % 3);
         for (int n = 0; n < nlit; n++)
            set_lit(t, int'(rnd() % span), rnd() % 2 == 0 ? LIT_HIGH : LIT_LOW);
      end
      for (int b = 0; b < SUM_W; b++) sum_cfg[b] = (rnd() % 4 == 0);
      xor_cfg = rnd();
      byp_cfg = rnd();
      ctl_terms();
   endtask

   function automatic string slice_tag(int k);
      if (byp_cfg[k]) return "R2 R5 fast path";
      if (xor_cfg[k]) return "R4 R5 xor path";
      return "R3 R5 wide path";
   endfunction

   task automatic comb_check();
      logic [N_OUT-1:0] e = mvec(din);
      for (int k = 0; k < N_OUT; k++) check(slice_tag(k), dout[k], e[k]);
      check("R10 enable term", oe, mterm(T_OE, din));
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000 && !done) begin
         done = 1;
         errors++;
         checks++;
         $display("FAIL watchdog expired actual=%0d expected<=%0d", cycles, 100000);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      logic [N_OUT-1:0] held;
      hand_cfg();
      reg_cfg = 4'hF;
      #1 rst_n = 1'b0;
      @(posedge clk); #1;
      check("R9 reset state", dout, 4'b0000);
      check("R10 enable at reset", oe, 1'b0);
      @(negedge clk); rst_n = 1'b1;
      @(posedge clk); #1;
      check("R6 first capture", dout, 4'b1001);

      // hand combinational patterns
      reg_cfg = 4'h0;
      for (int b = 0; b < 2; b++) begin
         din = '0; din[3] = b[0]; #1;
         check("R1 R2 R4 hand pattern", dout, {~b[0], b[0], 1'b0, 1'b1});
      end
      din = '0; din[14] = 1'b1; #1;
      check("R10 enable high", oe, 1'b1);
      din[15] = 1'b1; #1;
      check("R10 enable low", oe, 1'b0);

      // R8 term reset
      reg_cfg = 4'hF; din = '0;
      @(posedge clk); @(negedge clk);
      din[16] = 1'b1; #1;
      check("R8 reset term ignored", dout, 4'b1001);
      @(posedge clk); #1;
      check("R8 reset term ignored after edge", dout, 4'b1001);
      @(negedge clk); ptrst_en = 1'b1; #1;
      check("R8 async term reset", dout, 4'b0000);
      @(posedge clk); #1;
      check("R8 held in term reset", dout, 4'b0000);
      @(negedge clk); din[16] = 1'b0; #1;
      check("R8 release waits for edge", dout, 4'b0000);
      @(posedge clk); #1;
      check("R8 reload after release", dout, 4'b1001);
      @(negedge clk); ptrst_en = 1'b0;

      // R9 mid-cycle global reset
      @(posedge clk); #2; rst_n = 1'b0; #1;
      check("R9 async global reset", dout, 4'b0000);
      @(posedge clk); #1;
      check("R9 held in reset", dout, 4'b0000);
      @(negedge clk); rst_n = 1'b1;
      @(posedge clk); #1;
      check("R9 reload after reset", dout, 4'b1001);

      // R7 term clock
      @(negedge clk); rst_n = 1'b0; ptclk_sel = 1'b1; din = '0;
      @(negedge clk); rst_n = 1'b1;
      @(negedge clk); din[3] = 1'b1;
      @(posedge clk); #1;
      check("R7 global clock ignored", dout, 4'b0000);
      @(negedge clk); din[17] = 1'b1; #1;
      check("R7 term clock capture", dout, 4'b0101);
      @(negedge clk); din[3] = 1'b0; din[17] = 1'b0; #1;
      check("R7 falling term edge", dout, 4'b0101);
      @(posedge clk); #1;
      check("R7 global edge ignored", dout, 4'b0101);
      @(negedge clk); din[17] = 1'b1; #1;
      check("R7 second capture", dout, 4'b1001);
      @(negedge clk); din[17] = 1'b0;
      @(negedge clk); rst_n = 1'b0; ptclk_sel = 1'b0;
      @(negedge clk); rst_n = 1'b1;

      // combinational sweeps over the low byte
      reg_cfg = 4'h0;
      for (int c = 0; c < 6; c++) begin
         logic [N_IN-1:0] upper = rnd();
         rand_cfg(8);
         for (int v = 0; v < 256; v++) begin
            din = {upper[N_IN-1:8], v[7:0]};
            #1 comb_check();
         end
      end
      for (int c = 0; c < 2; c++) begin
         rand_cfg(N_IN);
         for (int v = 0; v < 512; v++) begin
            din = rnd();
            #1 comb_check();
         end
      end

      // registered sweeps with the global clock
      rand_cfg(8);
      @(negedge clk); reg_cfg = 4'hF;
      for (int n = 0; n < 64; n++) begin
         logic [N_OUT-1:0] e;
         @(negedge clk); din = rnd(); din[16] = 1'b0; e = mvec(din);
         @(posedge clk); #1;
         check("R6 capture", dout, e);
         #1 din = rnd(); #1;
         check("R6 hold between edges", dout, e);
      end
      @(negedge clk); reg_cfg = 4'b0101;
      for (int n = 0; n < 32; n++) begin
         @(negedge clk); din = rnd(); held = mvec(din);
         @(posedge clk); #1 din = rnd(); #1;
         check("R5 R6 mixed slices", dout,
               (reg_cfg & held) | (~reg_cfg & mvec(din)));
      end

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule